// File: doc/BRIEF.md
# Code Fetch Steering with Lock Protection

This block sits between the core's code-request path and two code sources: a 4 KB internal code store and an external memory bus. For each request it decides which source serves it and whether the request must be refused. A request can be an instruction fetch, a table read issued by an instruction, a verify read or program write from a programming port, or a read of the lock bits. The decision depends on four things: the external-access strap level, three non-volatile lock bits, the request address, and whether the requesting instruction was itself fetched from external memory.

Each additional lock bit tightens protection. The first lock bit does three things: it freezes the strap at its value during chip reset, it stops code running from external memory from reading internal bytes with table reads, and it refuses programming. The second lock bit also refuses verify read-back. The third lock bit also refuses execution from external memory.

A refused read returns the filler byte FFh and raises a one-cycle deny flag. A mismatch between the frozen strap and the live pin is reported on a fault output, and routing keeps using the frozen value. All outputs are registered and appear one clock after the request.

Top module: `fetch_steer`

## Requirements
- R1: With no lock bit programmed and the strap low, every instruction fetch (req_kind 0) selects the external bus (sel_ext_o=1, sel_int_o=0), whatever the address.
- R2: With the effective strap high, a fetch to an address below 1000h selects the internal store. A fetch to 1000h or above selects the external bus.
- R3: Protection levels are cumulative. lock_bits[0] is the first bit. A programmed bit 2 alone acts as if all three bits were programmed, and bit 1 alone acts as if bits 0 and 1 were programmed.
- R4: At level 1 or higher, a table read (req_kind 1) is denied when it is issued by externally fetched code (req_from_ext=1) and targets the internal region. The same read from internally fetched code is served from the internal store with rdata_o = mem_rdata.
- R5: The strap is captured while chip_rst is high. At level 1 or higher, routing uses the captured value instead of the live pin.
- R6: At level 1 or higher, a program request (req_kind 3) is denied. At level 0 it selects the internal store.
- R7: At level 2 or higher, a verify read (req_kind 2) is denied. Below level 2 it is served internally with rdata_o = mem_rdata.
- R8: At level 3, a fetch that would go to the external bus is denied. A fetch to the internal region is still served.
- R9: A lock read (req_kind 4) is never denied. It returns the lock bits in rdata_o[2:0] with the upper bits zero, and asserts neither select.
- R10: A denied request gives deny_o=1, rdata_o=FFh and both selects low in the following cycle only.
- R11: strap_fault_o is high one cycle after a cycle in which the level is at least 1, chip_rst is low, and the captured strap differs from the live pin.
- R12: Outputs change one cycle after a request. With req_valid low, or with req_kind 5 to 7, both selects and deny_o are low and rdata_o holds its value. After reset, the selects, deny_o and strap_fault_o are 0 and rdata_o is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chip_rst | input | 1 | Chip reset phase; the strap is captured while high |
| strap_pin | input | 1 | Live external-access strap level |
| lock_bits | input | 3 | Programmed lock bits, bit 0 first |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 fetch, 1 table read, 2 verify, 3 program, 4 lock read |
| req_from_ext | input | 1 | Requesting instruction came from external memory |
| req_addr | input | 16 | Request address |
| mem_rdata | input | 8 | Byte returned by the selected code source |
| sel_int_o | output | 1 | Internal store selected |
| sel_ext_o | output | 1 | External bus selected |
| deny_o | output | 1 | Request refused |
| rdata_o | output | 8 | Returned byte, FFh when refused |
| strap_fault_o | output | 1 | Captured strap differs from live pin |

## Verification
The bench probes the region edge at 0FFFh and 1000h. An off-by-one compare there would send the last internal byte outside or leak the first external address inside. It programs only the upper lock bits, so a design that treats each bit on its own would let verify or table reads through at what is really a higher level. It moves the strap pin after capture and checks that routing ignores the move while the fault output reports it; a design routing on the live pin would switch sources. It also checks that deny clears on the next idle cycle, and that lock reads still answer when everything else is locked.

// File: rtl/fetch_steer_pkg.sv
package fetch_steer_pkg;

  localparam int LOCK_N = 3;

  typedef enum logic [2:0] {
    REQ_FETCH  = 3'd0,
    REQ_TABLE  = 3'd1,
    REQ_VERIFY = 3'd2,
    REQ_PROG   = 3'd3,
    REQ_LOCKRD = 3'd4
  } req_kind_e;

  typedef struct packed {
    logic sel_int;
    logic sel_ext;
    logic deny;
    logic use_mem;
    logic use_lock;
  } route_t;

endpackage

// File: rtl/fetch_lock_levels.sv
module fetch_lock_levels
  import fetch_steer_pkg::*;
(
  input  logic [LOCK_N-1:0] lock_bits,
  output logic [LOCK_N-1:0] prot_o
);

  // level i is active when bit i or any higher bit is programmed
  for (genvar i = 0; i < LOCK_N; i++) begin : g_lvl
    assign prot_o[i] = |lock_bits[LOCK_N-1:i];
  end

endmodule

// File: rtl/fetch_strap_hold.sv
module fetch_strap_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_rst,
  input  logic strap_pin,
  input  logic lock_on,
  output logic strap_eff_o,
  output logic fault_o
);

  logic held_q, held_d;
  logic fault_q, fault_d;

  always_comb begin
    held_d  = held_q;
    if (chip_rst) held_d = strap_pin;
    fault_d = lock_on && !chip_rst && (held_q != strap_pin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      held_q  <= held_d;
      fault_q <= fault_d;
    end
  end

  assign strap_eff_o = lock_on ? held_q : strap_pin;
  assign fault_o     = fault_q;

endmodule

// File: rtl/fetch_route.sv
module fetch_route
  import fetch_steer_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INT_BYTES = 4096
) (
  input  logic [2:0]        kind,
  input  logic              from_ext,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strap_eff,
  input  logic [LOCK_N-1:0] prot,
  output route_t            route_o
);

  localparam logic [ADDR_W-1:0] INT_LIMIT = ADDR_W'(INT_BYTES);

  logic in_low;
  logic tgt_int;

  assign in_low  = addr < INT_LIMIT;
  assign tgt_int = strap_eff && in_low;

  always_comb begin
    route_o = '0;
    case (req_kind_e'(kind))
      REQ_FETCH: begin
        if (tgt_int)      route_o.sel_int = 1'b1;
        else if (prot[2]) route_o.deny    = 1'b1;
        else              route_o.sel_ext = 1'b1;
        route_o.use_mem = !route_o.deny;
      end
      REQ_TABLE: begin
        if (tgt_int && prot[0] && from_ext) route_o.deny    = 1'b1;
        else if (tgt_int)                   route_o.sel_int = 1'b1;
        else                                route_o.sel_ext = 1'b1;
        route_o.use_mem = !route_o.deny;
      end
      REQ_VERIFY: begin
        if (prot[1]) route_o.deny = 1'b1;
        else begin
          route_o.sel_int = 1'b1;
          route_o.use_mem = 1'b1;
        end
      end
      REQ_PROG: begin
        if (prot[0]) route_o.deny    = 1'b1;
        else         route_o.sel_int = 1'b1;
      end
      REQ_LOCKRD: route_o.use_lock = 1'b1;
      default:    route_o = '0;
    endcase
  end

endmodule

// File: rtl/fetch_steer.sv
module fetch_steer
  import fetch_steer_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_rst,
  input  logic              strap_pin,
  input  logic [LOCK_N-1:0] lock_bits,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              req_from_ext,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              sel_int_o,
  output logic              sel_ext_o,
  output logic              deny_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              strap_fault_o
);

  localparam logic [DATA_W-1:0] FILLER = '1;

  logic [LOCK_N-1:0] prot;
  logic              strap_eff;
  route_t            route;

  fetch_lock_levels u_lvl (
    .lock_bits (lock_bits),
    .prot_o    (prot)
  );

  fetch_strap_hold u_strap (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_rst    (chip_rst),
    .strap_pin   (strap_pin),
    .lock_on     (prot[0]),
    .strap_eff_o (strap_eff),
    .fault_o     (strap_fault_o)
  );

  fetch_route #(
    .ADDR_W    (ADDR_W),
    .INT_BYTES (INT_BYTES)
  ) u_route (
    .kind      (req_kind),
    .from_ext  (req_from_ext),
    .addr      (req_addr),
    .strap_eff (strap_eff),
    .prot      (prot),
    .route_o   (route)
  );

  logic              sel_int_q, sel_int_d;
  logic              sel_ext_q, sel_ext_d;
  logic              deny_q, deny_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  always_comb begin
    sel_int_d = req_valid && route.sel_int;
    sel_ext_d = req_valid && route.sel_ext;
    deny_d    = req_valid && route.deny;
    rdata_en  = req_valid && (route.deny || route.use_mem || route.use_lock);
    if (route.deny)          rdata_d = FILLER;
    else if (route.use_lock) rdata_d = {{(DATA_W-LOCK_N){1'b0}}, lock_bits};
    else                     rdata_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_int_q <= 1'b0;
      sel_ext_q <= 1'b0;
      deny_q    <= 1'b0;
      rdata_q   <= FILLER;
    end else begin
      sel_int_q <= sel_int_d;
      sel_ext_q <= sel_ext_d;
      deny_q    <= deny_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign sel_int_o = sel_int_q;
  assign sel_ext_o = sel_ext_q;
  assign deny_o    = deny_q;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/fetch_steer_chk.sv
module fetch_steer_chk
  import fetch_steer_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_BYTES = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_pin,
  input logic [LOCK_N-1:0] lock_bits,
  input logic              req_valid,
  input logic [2:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic              sel_int_o,
  input logic              sel_ext_o,
  input logic              deny_o,
  input logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(INT_BYTES);

  assert_sel_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_int_o, sel_ext_o}));

  assert_deny_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    deny_o |-> (!sel_int_o && !sel_ext_o && rdata_o == '1));

  assert_low_strap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd0 && lock_bits == '0 && !strap_pin) |=> sel_ext_o);

  assert_int_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd0 && lock_bits == '0 && strap_pin && req_addr < LIMIT)
      |=> sel_int_o);

  assert_prog_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd3 && lock_bits != '0) |=> deny_o);

  assert_verify_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd2 && (lock_bits[1] || lock_bits[2])) |=> deny_o);

  assert_lock_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd4)
      |=> (!deny_o && rdata_o[LOCK_N-1:0] == $past(lock_bits)
           && rdata_o[DATA_W-1:LOCK_N] == '0));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!sel_int_o && !sel_ext_o && !deny_o && $stable(rdata_o)));

endmodule

bind fetch_steer fetch_steer_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .INT_BYTES (INT_BYTES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .strap_pin (strap_pin),
  .lock_bits (lock_bits),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_addr  (req_addr),
  .sel_int_o (sel_int_o),
  .sel_ext_o (sel_ext_o),
  .deny_o    (deny_o),
  .rdata_o   (rdata_o)
);

// File: tb/fetch_steer_tb_top.sv
`timescale 1ns/1ps
module fetch_steer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n, chip_rst, strap_pin;
  logic [2:0]  lock_bits;
  logic        req_valid, req_from_ext;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  mem_rdata;
  logic        sel_int_o, sel_ext_o, deny_o, strap_fault_o;
  logic [7:0]  rdata_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  logic       m_latch;
  logic [7:0] m_rdata;

  always #4 clk = ~clk;

  fetch_steer dut_i (
    .clk(clk), .rst_n(rst_n), .chip_rst(chip_rst), .strap_pin(strap_pin),
    .lock_bits(lock_bits), .req_valid(req_valid), .req_kind(req_kind),
    .req_from_ext(req_from_ext), .req_addr(req_addr), .mem_rdata(mem_rdata),
    .sel_int_o(sel_int_o), .sel_ext_o(sel_ext_o), .deny_o(deny_o),
    .rdata_o(rdata_o), .strap_fault_o(strap_fault_o)
  );

  // expected {sel_int, sel_ext, deny} from the requirements
  function automatic logic [2:0] exp_route(input logic v, input logic [2:0] k,
                                           input logic fe, input logic [15:0] a,
                                           input logic [2:0] lk, input logic pin,
                                           input logic lat);
    logic l1, l2, l3, se, low;
    l1 = |lk; l2 = lk[2] | lk[1]; l3 = lk[2];
    se  = l1 ? lat : pin;
    low = a < 16'h1000;
    if (!v) return 3'b000;
    case (k)
      3'd0: return (se && low) ? 3'b100 : (l3 ? 3'b001 : 3'b010);
      3'd1: return (se && low) ? ((l1 && fe) ? 3'b001 : 3'b100) : 3'b010;
      3'd2: return l2 ? 3'b001 : 3'b100;
      3'd3: return l1 ? 3'b001 : 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %03h expected %03h (sel_int sel_ext deny fault rdata)", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [2:0] k,
                      input logic fe, input logic [15:0] a, input logic [7:0] md);
    logic [2:0] r;
    logic       f;
    req_valid = v; req_kind = k; req_from_ext = fe; req_addr = a; mem_rdata = md;
    r = exp_route(v, k, fe, a, lock_bits, strap_pin, m_latch);
    f = (|lock_bits) && !chip_rst && (m_latch != strap_pin);
    if (v && r[0])                                      m_rdata = 8'hFF;
    else if (v && k == 3'd4)                            m_rdata = {5'b0, lock_bits};
    else if (v && (r[2] || r[1]) && k != 3'd3)          m_rdata = md;
    if (chip_rst) m_latch = strap_pin;
    @(posedge clk);
    @(negedge clk);
    check(tag, {sel_int_o, sel_ext_o, deny_o, strap_fault_o, rdata_o}, {r, f, m_rdata});
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b0; chip_rst = 1'b1; strap_pin = 1'b1; lock_bits = 3'b000;
    req_valid = 1'b0; req_kind = 3'd0; req_from_ext = 1'b0; req_addr = '0; mem_rdata = '0;
    m_latch = 1'b0; m_rdata = 8'hFF;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", {sel_int_o, sel_ext_o, deny_o, strap_fault_o, rdata_o}, {4'b0000, 8'hFF});
    rst_n = 1'b1;
    step("R5 capture", 1'b0, 3'd0, 1'b0, 16'h0, 8'h00);
    step("R5 capture", 1'b0, 3'd0, 1'b0, 16'h0, 8'h00);
    chip_rst = 1'b0;

    strap_pin = 1'b0;
    step("R1 low strap", 1'b1, 3'd0, 1'b0, 16'h0010, 8'h11);
    strap_pin = 1'b1;
    step("R2 last internal", 1'b1, 3'd0, 1'b0, 16'h0FFF, 8'h22);
    step("R2 first external", 1'b1, 3'd0, 1'b0, 16'h1000, 8'h33);
    step("R4 unlocked table", 1'b1, 3'd1, 1'b1, 16'h0100, 8'h44);
    step("R6 unlocked program", 1'b1, 3'd3, 1'b0, 16'h0100, 8'h00);

    lock_bits = 3'b001;
    step("R4 table from ext denied", 1'b1, 3'd1, 1'b1, 16'h0200, 8'h55);
    step("R10 deny clears", 1'b0, 3'd0, 1'b0, 16'h0, 8'h00);
    step("R4 table from int", 1'b1, 3'd1, 1'b0, 16'h0200, 8'h66);
    step("R6 program denied", 1'b1, 3'd3, 1'b0, 16'h0300, 8'h00);
    step("R7 level1 verify", 1'b1, 3'd2, 1'b0, 16'h0300, 8'h77);
    strap_pin = 1'b0;
    step("R11 fault", 1'b1, 3'd0, 1'b0, 16'h0010, 8'h88);
    step("R5 latched routing", 1'b1, 3'd0, 1'b0, 16'h0020, 8'h99);
    strap_pin = 1'b1;

    lock_bits = 3'b011;
    step("R7 verify denied", 1'b1, 3'd2, 1'b0, 16'h0040, 8'hAA);
    lock_bits = 3'b100;
    step("R3 bit2 verify", 1'b1, 3'd2, 1'b0, 16'h0040, 8'hAB);
    step("R3 bit2 table", 1'b1, 3'd1, 1'b1, 16'h0040, 8'hAC);
    step("R3 bit2 program", 1'b1, 3'd3, 1'b0, 16'h0040, 8'h00);
    lock_bits = 3'b111;
    step("R8 external fetch denied", 1'b1, 3'd0, 1'b0, 16'h2000, 8'hBB);
    step("R8 internal fetch", 1'b1, 3'd0, 1'b0, 16'h0800, 8'hBC);
    step("R9 lock read", 1'b1, 3'd4, 1'b0, 16'h0000, 8'hCC);
    step("R12 idle hold", 1'b0, 3'd1, 1'b1, 16'h0000, 8'hDD);
    step("R12 unused kind", 1'b1, 3'd6, 1'b0, 16'h0000, 8'hDE);

    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  k;
      logic [15:0] a;
      if ($urandom_range(15) == 0) chip_rst = ~chip_rst;
      if ($urandom_range(7) == 0)  strap_pin = $urandom_range(1);
      if ($urandom_range(15) == 0) lock_bits = 3'($urandom_range(7));
      k = 3'($urandom_range(5));
      a = $urandom_range(1) ? 16'($urandom_range(16'h0FFF)) : 16'($urandom);
      step("R3 random", $urandom_range(7) != 0, k, 1'($urandom_range(1)), a, 8'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule